// File: doc/BRIEF.md
# Tone-Shift Audio Bit Demodulator

This block turns a stream of signed 8-bit audio samples, taken at 9600 Hz, into 1200 bit/s data
bits ready for a frame deframer. Each sample is multiplied by the sample taken half a bit earlier, which
turns the tone frequency into a level. That level goes through a first-order low-pass filter built from
shifts and adds. The filter output is then cut to a single hard decision. A digital phase accumulator
picks one instant per bit, and on every edge of the hard decision it moves a little toward the middle of
the bit. At each chosen instant the bit value is a two-of-three vote over the latest hard decisions. A
transition-coded decode then gives the data bit.

A small sequencer does the work for one sample in three steps. In `S_IDLE` it waits for `sample_valid`.
Taking a sample moves it to `S_FILT`, where the filter and the slicer update. It then moves to
`S_TRACK`, where the phase updates and a bit may be sent out, and from there it always goes back to
`S_IDLE`. Samples must therefore arrive at least three clock cycles apart. At audio rates this is always
true.

Top module: `afsk_demod`

## Requirements
- R1: After reset, `bit_valid` is 0, the phase is 0, the half-bit delay line holds four zero samples, the filter state is 0 and the previous recovered bit is 0.
- R2: A sample is taken only when `sample_valid` is high in `S_IDLE`. The path is always `S_IDLE` then `S_FILT` then `S_TRACK` then back to `S_IDLE`. A `sample_valid` that is high in `S_FILT` or `S_TRACK` has no effect.
- R3: The discriminator term is the product of the current sample and the sample taken four samples earlier, shifted right arithmetically by 2, in signed 16-bit.
- R4: The filter output is y = x[n-1] + x[n] + (y>>>1) + (y>>>3) + (y>>>5), computed in signed 16-bit with wrap-around.
- R5: The hard decision is 1 only when the new filter output is strictly positive. A zero output gives 0.
- R6: For every sample the phase advances by 8. When the result is 64 or more, 64 is subtracted and a bit is sent out.
- R7: When the two newest hard decisions differ, the phase first moves by 1 before the advance. It moves up if the phase is below 32 and down otherwise.
- R8: The raw bit value is 1 when at least two of the three newest hard decisions are 1.
- R9: `bit_out` is 1 when the raw bit equals the raw bit recovered before it, and 0 when they differ.
- R10: `bit_valid` is a one-cycle pulse. It is high in the cycle after the third rising edge counted from the edge that took the sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Marks a new audio sample |
| sample_in | input | 8 | Signed audio sample |
| bit_valid | output | 1 | Pulse: a recovered bit is present |
| bit_out | output | 1 | Decoded data bit, valid with `bit_valid` |

## Verification
The assertions check, on every cycle, the rules that hold at any instant. The sequencer never leaves
`S_FILT` for anything but `S_TRACK`. The phase stays below its maximum, and it has just wrapped into
its lowest band whenever a bit goes out. `bit_valid` never lasts two cycles. The arithmetic cannot be
checked that way. This covers the delay-product value, the filter recursion, the edge nudges and the
vote/decode results. These show only in the bench scenarios, where an independent arithmetic model is
fed the same sequences: silence, steady and keyed tones, full-scale extremes, pseudo-random noise and
held sample strobes.

// File: rtl/afsk_pkg.sv
package afsk_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FILT  = 2'd1,
        S_TRACK = 2'd2
    } seq_state_t;
endpackage

// File: rtl/afsk_discrim.sv
module afsk_discrim #(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 16,
    parameter int DELAY    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept,
    input  logic                       filt_en,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic [2:0]                 slices
);
    localparam int EXT_W = ACC_W - SAMPLE_W;

    logic signed [SAMPLE_W-1:0] dly_q [DELAY];
    logic signed [ACC_W-1:0]    cur_ext, tap_ext, prod, x_new;
    logic signed [ACC_W-1:0]    x_prev_q, x_cur_q, y_q, y_next;

    // R3: half-bit delayed product
    always_comb begin
        cur_ext = {{EXT_W{sample_in[SAMPLE_W-1]}}, sample_in};
        tap_ext = {{EXT_W{dly_q[DELAY-1][SAMPLE_W-1]}}, dly_q[DELAY-1]};
        prod    = cur_ext * tap_ext;
        x_new   = prod >>> 2;
    end

    // R4: shift-and-add low-pass
    always_comb begin
        y_next = x_prev_q + x_cur_q + (y_q >>> 1) + (y_q >>> 3) + (y_q >>> 5);
    end

    generate
        for (genvar i = 0; i < DELAY; i++) begin : g_dly
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dly_q[i] <= '0;
                end else if (accept) begin
                    if (i == 0) dly_q[i] <= sample_in;
                    else        dly_q[i] <= dly_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev_q <= '0;
            x_cur_q  <= '0;
            y_q      <= '0;
            slices   <= '0;
        end else begin
            if (accept) begin
                x_prev_q <= x_cur_q;
                x_cur_q  <= x_new;
            end
            if (filt_en) begin
                y_q    <= y_next;
                slices <= {slices[1:0], (y_next > 0)};  // R5
            end
        end
    end
endmodule

// File: rtl/afsk_bitsync.sv
module afsk_bitsync #(
    parameter int SPB        = 8,
    parameter int PHASE_STEP = 8,
    parameter int NUDGE      = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       track_en,
    input  logic [2:0] slices,
    output logic       bit_valid,
    output logic       bit_out
);
    localparam int PHASE_MAX = SPB * PHASE_STEP;
    localparam int PHASE_THR = PHASE_MAX / 2;
    localparam int PW        = $clog2(PHASE_MAX + PHASE_STEP + NUDGE + 1);

    logic [PW-1:0] phase_q, phase_adj, phase_sum, phase_next;
    logic          edge_seen, emit, raw_bit, prev_bit_q;

    always_comb begin
        edge_seen = slices[0] ^ slices[1];
        phase_adj = phase_q;
        if (edge_seen) begin                                   // R7
            if (phase_q < PW'(PHASE_THR)) phase_adj = phase_q + PW'(NUDGE);
            else                          phase_adj = phase_q - PW'(NUDGE);
        end
        phase_sum  = phase_adj + PW'(PHASE_STEP);              // R6
        emit       = (phase_sum >= PW'(PHASE_MAX));
        phase_next = emit ? (phase_sum - PW'(PHASE_MAX)) : phase_sum;
        raw_bit    = (slices[0] & slices[1]) | (slices[0] & slices[2])
                   | (slices[1] & slices[2]);                  // R8
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= '0;
            prev_bit_q <= 1'b0;
            bit_valid  <= 1'b0;
            bit_out    <= 1'b0;
        end else begin
            bit_valid <= track_en && emit;
            if (track_en) begin
                phase_q <= phase_next;
                if (emit) begin
                    prev_bit_q <= raw_bit;
                    bit_out    <= (raw_bit == prev_bit_q);     // R9
                end
            end
        end
    end

    a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < PW'(PHASE_MAX));
    a_r6_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> phase_q < PW'(PHASE_STEP + NUDGE));
endmodule

// File: rtl/afsk_demod.sv
module afsk_demod
    import afsk_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int ACC_W      = 16,
    parameter int SPB        = 8,
    parameter int PHASE_STEP = 8,
    parameter int NUDGE      = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                bit_valid,
    output logic                bit_out
);
    localparam int DELAY = SPB / 2;

    seq_state_t state_q, state_next;
    logic       accept, filt_en, track_en;
    logic [2:0] slices;

    always_comb begin
        state_next = state_q;
        unique case (state_q)
            S_IDLE:  if (sample_valid) state_next = S_FILT;
            S_FILT:  state_next = S_TRACK;
            S_TRACK: state_next = S_IDLE;
            default: state_next = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_next;
    end

    always_comb begin
        accept   = (state_q == S_IDLE) && sample_valid;   // R2
        filt_en  = (state_q == S_FILT);
        track_en = (state_q == S_TRACK);
    end

    afsk_discrim #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .DELAY(DELAY)) u_discrim (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .filt_en   (filt_en),
        .sample_in (sample_in),
        .slices    (slices)
    );

    afsk_bitsync #(.SPB(SPB), .PHASE_STEP(PHASE_STEP), .NUDGE(NUDGE)) u_bitsync (
        .clk       (clk),
        .rst_n     (rst_n),
        .track_en  (track_en),
        .slices    (slices),
        .bit_valid (bit_valid),
        .bit_out   (bit_out)
    );

    a_r2_filt_to_track: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_FILT |=> state_q == S_TRACK);
    a_r2_track_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_TRACK |=> state_q == S_IDLE);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
    a_r10_after_track: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> state_q == S_IDLE);
endmodule

// File: tb/afsk_demod_tb.sv
module afsk_demod_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_valid = 1'b0;
    logic [7:0] sample_in = '0;
    logic       bit_valid, bit_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // reference model state
    shortint m_dly [4];
    shortint m_xp, m_xc, m_y;
    int      m_phase;
    bit [2:0] m_sl;
    bit      m_prev;

    always #4 clk = ~clk;

    afsk_demod u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_in(sample_in), .bit_valid(bit_valid), .bit_out(bit_out)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_dly[i] = 0;
        m_xp = 0; m_xc = 0; m_y = 0; m_phase = 0; m_sl = 0; m_prev = 0;
    endtask

    // R3 R4 R5 R6 R7 R8 R9 model of one sample
    task automatic model_step(input byte s, output bit e, output bit b);
        shortint p, yn;
        bit raw;
        p = shortint'(s) * shortint'(m_dly[3]);
        for (int i = 3; i > 0; i--) m_dly[i] = m_dly[i-1];
        m_dly[0] = shortint'(s);
        m_xp = m_xc;
        m_xc = p >>> 2;
        yn = m_xp + m_xc + (m_y >>> 1) + (m_y >>> 3) + (m_y >>> 5);
        m_y = yn;
        m_sl = {m_sl[1:0], (yn > 0)};
        if (m_sl[0] != m_sl[1]) m_phase = (m_phase < 32) ? m_phase + 1 : m_phase - 1;
        m_phase += 8;
        e = 0; b = 0;
        if (m_phase >= 64) begin
            m_phase -= 64;
            e = 1;
            raw = (m_sl[0] & m_sl[1]) | (m_sl[0] & m_sl[2]) | (m_sl[1] & m_sl[2]);
            b = (raw == m_prev);
            m_prev = raw;
        end
    endtask

    task automatic feed(input byte s, input bit hold);
        bit e, b;
        model_step(s, e, b);
        @(negedge clk); sample_valid = 1'b1; sample_in = s;
        @(negedge clk); sample_valid = hold;
        check("R10 no early pulse", bit_valid, 1'b0);
        @(negedge clk);
        check("R10 no early pulse", bit_valid, 1'b0);
        @(negedge clk); sample_valid = 1'b0;
        check("R6 R7 R10 emission", bit_valid, e);
        if (e) check("R3 R4 R5 R8 R9 bit value", bit_out, b);
    endtask

    initial begin
        int acc;
        int inc;
        bit lb;
        bit [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset valid", bit_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", bit_valid, 1'b0);

        // silence: zero output slices 0, emit every 8th sample with bit 1 (R5 R9)
        for (int i = 0; i < 24; i++) feed(8'sd0, 1'b0);
        // full-scale extremes
        for (int i = 0; i < 16; i++) feed((i % 2) ? -8'sd128 : 8'sd127, 1'b0);
        for (int i = 0; i < 16; i++) feed(-8'sd128, 1'b0);
        // steady low tone, square wave with 8-sample period
        for (int i = 0; i < 64; i++) feed((i % 8 < 4) ? 8'sd90 : -8'sd90, 1'b0);
        // keyed tones: triangle from phase accumulator, tone toggles on data 0
        acc = 0; inc = 64; lfsr = 16'hACE1;
        for (int bi = 0; bi < 60; bi++) begin
            lb = lfsr[0];
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            if (!lb) inc = (inc == 64) ? 117 : 64;
            for (int k = 0; k < 8; k++) begin
                int t;
                acc = (acc + inc) % 512;
                t = (acc < 256) ? acc - 128 : 383 - acc;
                feed(byte'(t), 1'b0);
            end
        end
        // R2 held strobe: held valid counts as one sample
        for (int i = 0; i < 40; i++) feed((i % 5 < 2) ? 8'sd70 : -8'sd50, 1'b1);
        // pseudo-random noise
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            feed(byte'(lfsr[7:0]), (i % 7) == 0);
        end
        // mid-run reset returns to the R1 state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset valid again", bit_valid, 1'b0);
        model_reset();
        for (int i = 0; i < 16; i++) feed(8'sd0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule